// File: doc/BRIEF.md
# Page Table Walk Step Unit

This unit carries out a single step of a page table walk that a TLB refill handler drives one instruction at a time. It has two operations. A directory step takes a table pointer and a level from 1 to 4 and returns the pointer held in the next-level table, fetched over a 64-bit read port. A leaf step takes a table pointer and an even/odd selector and produces one half of a refill entry pair, together with the page size that the pair covers.

The bit position and width of the index field at each level come from configuration inputs. Level 0 holds the leaf table's pair. A two-bit entry-width code sets the table stride. Huge-page markers pass through the directory levels unchanged, except that the level where the huge page was found is recorded. At the leaf step a huge page is split into an even half and an odd half. The caller pulses `start` and waits for `done`. The results stay stable until the next accepted start.

Top module: `ptw_step`

## Requirements
- R1: While `rst` is high, `done`, `rd_req`, `huge_l4_warn`, `dir_out`, `lo0`, `lo1` and `ps_out` are all 0 one cycle later.
- R2: A legal directory step (level 1..4, bit 6 of `base` clear) issues one read. Its address is `(base & PA mask) | (((badv >> pos[L]) & ((1<<wid[L])-1)) << ((ew+1)*3))`, where `pos[L]` is `cfg_pos[L*6 +: 6]`, `wid[L]` is `cfg_wid[L*5 +: 5]` and PA mask keeps bits 47:0.
- R3: The directory result `dir_out` is the returned read data with bits 63:48 cleared.
- R4: A directory step with level 0 or a level above 4 makes no read and returns `base` unchanged in `dir_out`.
- R5: A directory step whose `base` has bit 6 set makes no read. If bits 14:13 of `base` are nonzero, it returns `base` as is. Otherwise it returns `base` with bits 14:13 set to the low two bits of the level.
- R6: A leaf step on a base with bit 6 clear reads one entry. The leaf index is `(badv >> pos[0]) & mask(wid[0])` with bit 0 cleared. The even entry is read at `base_m | (idx << stride)` and the odd entry at `base_m | ((idx+1) << stride)`. The entry is stored masked to 48 bits, and `ps_out` becomes `pos[0]`.
- R7: A leaf step on a masked base with bit 6 set makes no read. The entry is the base with bits 14:13 and bit 6 cleared. If bit 12 is set, bit 12 is cleared and bit 6 is set. With L taken from bits 14:13 of the base, `ps_out` becomes `pos[L] + wid[L] - 1`, and the odd half adds `1 << ps_out` to the entry.
- R8: An odd leaf step writes only `lo1`, an even leaf step writes only `lo0`, and both write `ps_out`. A directory step changes none of the three.
- R9: `rd_req` stays high with `rd_addr` stable until `rd_ack` is seen. Only one read is outstanding at a time, and a `start` that arrives while a read is pending is ignored.
- R10: `done` rises when a step completes and stays high, with all result outputs stable, until the next `start`.
- R11: A directory step on a huge base at level 4 raises `huge_l4_warn` until the next start. The returned value still follows R5.

Pin/config encoding: `op_leaf` is 1 for a leaf step and 0 for a directory step. `odd` is 1 for the odd half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a step (accepted unless a read is pending) |
| op_leaf | input | 1 | 1 = leaf step, 0 = directory step |
| level | input | 3 | Directory level (1..4 legal) |
| odd | input | 1 | Leaf half select, 1 = odd |
| base | input | 64 | Table pointer or huge entry |
| badv | input | 64 | Faulting virtual address |
| cfg_pos | input | 30 | Index bit positions, 6 bits per level 0..4 |
| cfg_wid | input | 25 | Index widths, 5 bits per level 0..4 |
| cfg_ew | input | 2 | Entry-width code (stride shift = (code+1)*3) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 64 | Read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 64 | Read data |
| done | output | 1 | Step complete, results valid |
| dir_out | output | 64 | Directory step result |
| lo0 | output | 64 | Even refill entry-low |
| lo1 | output | 64 | Odd refill entry-low |
| ps_out | output | 6 | Refill page-size field |
| huge_l4_warn | output | 1 | Huge base seen at a level-4 directory step |

## Verification
The assertions check on every cycle that the read handshake holds its address until acknowledged, that results and `done` are stable while no start arrives, that illegal-level and huge-base directory steps never raise a read, that the level-4 warning follows a huge base, and that reset clears the outputs. Only the bench's scenarios can show that the computed addresses, masked data, huge-page split arithmetic, page sizes and the even/odd write selection are correct. These need a model of the memory and of the configuration fields across several stride codes and levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int HUGE_BIT  = 6;
  localparam int GLB_BIT   = 6;
  localparam int HGLB_BIT  = 12;
  localparam int LVF_LO    = 13;
  localparam int LVF_HI    = 14;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } ptw_state_e;
endpackage

// File: rtl/ptw_lvl_sel.sv
module ptw_lvl_sel #(
  parameter int NLVL  = 5,
  parameter int POS_W = 6,
  parameter int WID_W = 5,
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0]      lvl,
  input  logic [NLVL*POS_W-1:0] cfg_pos,
  input  logic [NLVL*WID_W-1:0] cfg_wid,
  output logic [POS_W-1:0]      pos,
  output logic [WID_W-1:0]      wid
);
  logic [POS_W-1:0] pos_a [NLVL];
  logic [WID_W-1:0] wid_a [NLVL];

  for (genvar gi = 0; gi < NLVL; gi++) begin : g_unpack
    assign pos_a[gi] = cfg_pos[gi*POS_W +: POS_W];
    assign wid_a[gi] = cfg_wid[gi*WID_W +: WID_W];
  end

  // Out-of-range levels fall back to the leaf pair.
  always_comb begin
    pos = pos_a[0];
    wid = wid_a[0];
    for (int i = 1; i < NLVL; i++) begin
      if (lvl == LVL_W'(i)) begin
        pos = pos_a[i];
        wid = wid_a[i];
      end
    end
  end
endmodule

// File: rtl/ptw_tbl_addr.sv
module ptw_tbl_addr #(
  parameter int DW    = 64,
  parameter int POS_W = 6,
  parameter int WID_W = 5,
  parameter int EW_W  = 2
) (
  input  logic [DW-1:0]    badv,
  input  logic [DW-1:0]    base_m,
  input  logic [POS_W-1:0] pos,
  input  logic [WID_W-1:0] wid,
  input  logic [EW_W-1:0]  ew,
  input  logic             pair,
  input  logic             odd,
  output logic [DW-1:0]    addr
);
  localparam int SH_W = 6;

  logic [SH_W-1:0] stride;
  logic [DW-1:0]   idx_mask;
  logic [DW-1:0]   idx;

  always_comb begin
    stride   = SH_W'(3 * (32'(ew) + 1));
    idx_mask = (DW'(1) << wid) - DW'(1);
    idx      = (badv >> pos) & idx_mask;
    if (pair) begin
      idx[0] = 1'b0;
      idx    = idx + DW'(odd);
    end
    addr = base_m | (idx << stride);
  end
endmodule

// File: rtl/ptw_huge_split.sv
module ptw_huge_split
  import ptw_pkg::*;
#(
  parameter int DW    = 64,
  parameter int POS_W = 6,
  parameter int WID_W = 5
) (
  input  logic [DW-1:0]    base_m,
  input  logic [POS_W-1:0] pos,
  input  logic [WID_W-1:0] wid,
  input  logic             odd,
  output logic [DW-1:0]    entry,
  output logic [POS_W-1:0] ps
);
  logic [POS_W:0]  ps_full;
  logic [DW-1:0]   cleaned;

  always_comb begin
    cleaned                  = base_m;
    cleaned[LVF_HI:LVF_LO]   = '0;
    cleaned[HUGE_BIT]        = 1'b0;
    if (cleaned[HGLB_BIT]) begin
      cleaned[HGLB_BIT] = 1'b0;
      cleaned[GLB_BIT]  = 1'b1;
    end
    ps_full = {1'b0, pos} + (POS_W+1)'(wid) - (POS_W+1)'(1);
    ps      = ps_full[POS_W-1:0];
    entry   = odd ? (cleaned + (DW'(1) << ps)) : cleaned;
  end
endmodule

// File: rtl/ptw_step.sv
module ptw_step
  import ptw_pkg::*;
#(
  parameter int DW    = 64,
  parameter int PA_W  = 48,
  parameter int NLVL  = 5,
  parameter int POS_W = 6,
  parameter int WID_W = 5,
  parameter int LVL_W = 3,
  parameter int EW_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  op_leaf,
  input  logic [LVL_W-1:0]      level,
  input  logic                  odd,
  input  logic [DW-1:0]         base,
  input  logic [DW-1:0]         badv,
  input  logic [NLVL*POS_W-1:0] cfg_pos,
  input  logic [NLVL*WID_W-1:0] cfg_wid,
  input  logic [EW_W-1:0]       cfg_ew,
  output logic                  rd_req,
  output logic [DW-1:0]         rd_addr,
  input  logic                  rd_ack,
  input  logic [DW-1:0]         rd_data,
  output logic                  done,
  output logic [DW-1:0]         dir_out,
  output logic [DW-1:0]         lo0,
  output logic [DW-1:0]         lo1,
  output logic [POS_W-1:0]      ps_out,
  output logic                  huge_l4_warn
);
  localparam logic [DW-1:0] PA_MASK = {{(DW-PA_W){1'b0}}, {PA_W{1'b1}}};
  localparam int            TOP_LVL = NLVL - 1;

  ptw_state_e state;
  logic       pend_leaf, pend_odd;
  logic [POS_W-1:0] pend_ps;

  logic [DW-1:0]    base_m;
  logic             accept;
  logic             lvl_bad;
  logic [POS_W-1:0] d_pos, h_pos, l_pos;
  logic [WID_W-1:0] d_wid, h_wid, l_wid;
  logic [DW-1:0]    dir_addr, leaf_addr;
  logic [DW-1:0]    h_entry;
  logic [POS_W-1:0] h_ps;
  logic [DW-1:0]    dir_huge_res;

  assign base_m  = base & PA_MASK;
  assign accept  = start && (state != ST_WAIT);
  assign lvl_bad = (level == '0) || (level > LVL_W'(TOP_LVL));

  // Directory level pair
  ptw_lvl_sel #(.NLVL(NLVL), .POS_W(POS_W), .WID_W(WID_W), .LVL_W(LVL_W)) u_sel_dir (
    .lvl(level), .cfg_pos(cfg_pos), .cfg_wid(cfg_wid), .pos(d_pos), .wid(d_wid)
  );

  // Huge leaf: level recorded in the entry
  ptw_lvl_sel #(.NLVL(NLVL), .POS_W(POS_W), .WID_W(WID_W), .LVL_W(LVL_W)) u_sel_huge (
    .lvl(LVL_W'(base_m[LVF_HI:LVF_LO])), .cfg_pos(cfg_pos), .cfg_wid(cfg_wid),
    .pos(h_pos), .wid(h_wid)
  );

  // Leaf table pair
  ptw_lvl_sel #(.NLVL(NLVL), .POS_W(POS_W), .WID_W(WID_W), .LVL_W(LVL_W)) u_sel_leaf (
    .lvl('0), .cfg_pos(cfg_pos), .cfg_wid(cfg_wid), .pos(l_pos), .wid(l_wid)
  );

  ptw_tbl_addr #(.DW(DW), .POS_W(POS_W), .WID_W(WID_W), .EW_W(EW_W)) u_addr_dir (
    .badv(badv), .base_m(base_m), .pos(d_pos), .wid(d_wid), .ew(cfg_ew),
    .pair(1'b0), .odd(1'b0), .addr(dir_addr)
  );

  ptw_tbl_addr #(.DW(DW), .POS_W(POS_W), .WID_W(WID_W), .EW_W(EW_W)) u_addr_leaf (
    .badv(badv), .base_m(base_m), .pos(l_pos), .wid(l_wid), .ew(cfg_ew),
    .pair(1'b1), .odd(odd), .addr(leaf_addr)
  );

  ptw_huge_split #(.DW(DW), .POS_W(POS_W), .WID_W(WID_W)) u_split (
    .base_m(base_m), .pos(h_pos), .wid(h_wid), .odd(odd), .entry(h_entry), .ps(h_ps)
  );

  always_comb begin
    dir_huge_res = base;
    if (base[LVF_HI:LVF_LO] == '0) begin
      dir_huge_res[LVF_HI:LVF_LO] = level[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rd_req       <= 1'b0;
      rd_addr      <= '0;
      dir_out      <= '0;
      lo0          <= '0;
      lo1          <= '0;
      ps_out       <= '0;
      huge_l4_warn <= 1'b0;
      pend_leaf    <= 1'b0;
      pend_odd     <= 1'b0;
      pend_ps      <= '0;
    end else if (accept) begin
      huge_l4_warn <= 1'b0;
      if (!op_leaf) begin
        if (lvl_bad) begin
          dir_out <= base;
          state   <= ST_DONE;
        end else if (base[HUGE_BIT]) begin
          dir_out      <= dir_huge_res;
          huge_l4_warn <= (level == LVL_W'(TOP_LVL));
          state        <= ST_DONE;
        end else begin
          rd_addr   <= dir_addr;
          rd_req    <= 1'b1;
          pend_leaf <= 1'b0;
          state     <= ST_WAIT;
        end
      end else begin
        if (base_m[HUGE_BIT]) begin
          if (odd) lo1 <= h_entry;
          else     lo0 <= h_entry;
          ps_out <= h_ps;
          state  <= ST_DONE;
        end else begin
          rd_addr   <= leaf_addr;
          rd_req    <= 1'b1;
          pend_leaf <= 1'b1;
          pend_odd  <= odd;
          pend_ps   <= l_pos;
          state     <= ST_WAIT;
        end
      end
    end else if (state == ST_WAIT && rd_ack) begin
      rd_req <= 1'b0;
      state  <= ST_DONE;
      if (pend_leaf) begin
        if (pend_odd) lo1 <= rd_data & PA_MASK;
        else          lo0 <= rd_data & PA_MASK;
        ps_out <= pend_ps;
      end else begin
        dir_out <= rd_data & PA_MASK;
      end
    end
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/ptw_step_chk.sv
module ptw_step_chk #(
  parameter int DW    = 64,
  parameter int POS_W = 6,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             op_leaf,
  input logic [LVL_W-1:0] level,
  input logic [DW-1:0]    base,
  input logic             rd_req,
  input logic             rd_ack,
  input logic [DW-1:0]    rd_addr,
  input logic             done,
  input logic [DW-1:0]    dir_out,
  input logic [DW-1:0]    lo0,
  input logic [DW-1:0]    lo1,
  input logic [POS_W-1:0] ps_out,
  input logic             huge_l4_warn
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!done && !rd_req && !huge_l4_warn && dir_out == '0 && lo0 == '0 && lo1 == '0));

  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  a_r9_no_done_while_req: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !done);

  a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(dir_out) && $stable(lo0) && $stable(lo1)
                          && $stable(ps_out) && $stable(huge_l4_warn)));

  a_r4_illegal_no_read: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && !op_leaf && (level == '0 || level > LVL_W'(4))) |=> (!rd_req && done));

  a_r5_huge_dir_no_read: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && !op_leaf && base[6]) |=> (!rd_req && done));

  a_r11_l4_huge_warn: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && !op_leaf && base[6] && level == LVL_W'(4)) |=> huge_l4_warn);

  a_r8_dir_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && !op_leaf) |=> ($stable(lo0) && $stable(lo1) && $stable(ps_out)));
endmodule

bind ptw_step ptw_step_chk #(.DW(DW), .POS_W(POS_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_leaf(op_leaf), .level(level), .base(base),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr), .done(done), .dir_out(dir_out),
  .lo0(lo0), .lo1(lo1), .ps_out(ps_out), .huge_l4_warn(huge_l4_warn)
);

// File: tb/ptw_step_test.sv
module ptw_step_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PAM = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op_leaf = 1'b0, odd = 1'b0;
  logic [2:0]  level = '0;
  logic [63:0] base = '0, badv = '0;
  logic [29:0] cfg_pos;
  logic [24:0] cfg_wid;
  logic [1:0]  cfg_ew = '0;
  logic        rd_req, rd_ack = 1'b0;
  logic [63:0] rd_addr, rd_data = '0;
  logic        done, huge_l4_warn;
  logic [63:0] dir_out, lo0, lo1;
  logic [5:0]  ps_out;

  ptw_step uut (
    .clk(clk), .rst(rst), .start(start), .op_leaf(op_leaf), .level(level), .odd(odd),
    .base(base), .badv(badv), .cfg_pos(cfg_pos), .cfg_wid(cfg_wid), .cfg_ew(cfg_ew),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .dir_out(dir_out), .lo0(lo0), .lo1(lo1), .ps_out(ps_out),
    .huge_l4_warn(huge_l4_warn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int pos_t [5] = '{12, 21, 30, 39, 48};
  int wid_t [5] = '{9, 9, 9, 9, 8};
  initial begin
    for (int i = 0; i < 5; i++) begin
      cfg_pos[i*6 +: 6] = 6'(pos_t[i]);
      cfg_wid[i*5 +: 5] = 5'(wid_t[i]);
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  int latency = 1, lat_cnt = 0, nreads = 0;
  logic [63:0] last_addr = '0, hold_addr = '0;
  logic        hold_req = 1'b0;

  // Expected model state
  logic [63:0] e_dir = '0, e_lo0 = '0, e_lo1 = '0;
  logic [5:0]  e_ps = '0;
  logic        e_warn = 1'b0;
  logic        mon_en = 1'b0;

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return (a ^ 64'hF0F0_1234_5678_9ABC) + (a << 5);
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // Memory responder with programmable latency
  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack <= 1'b0;
    end else if (rd_req) begin
      lat_cnt = lat_cnt + 1;
      if (lat_cnt >= latency) begin
        rd_ack    <= 1'b1;
        rd_data   <= mem_word(rd_addr);
        last_addr = rd_addr;
        nreads    = nreads + 1;
        lat_cnt   = 0;
      end
    end
  end

  // Per-clock monitor: request hold (R9) and held results (R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_req && rd_req) chk("R9 addr held", rd_addr, hold_addr);
      hold_req  = rd_req && !rd_ack;
      hold_addr = rd_addr;
      if (mon_en && done) begin
        chk("R10 dir held", dir_out, e_dir);
        chk("R10 lo0 held", lo0, e_lo0);
        chk("R10 lo1 held", lo1, e_lo1);
        chk("R10 ps held", 64'(ps_out), 64'(e_ps));
        chk("R10 warn held", 64'(huge_l4_warn), 64'(e_warn));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_step(input logic lf, input logic [2:0] lv, input logic od,
                          input logic [63:0] b, input int lat, input logic busy_poke,
                          input string rq);
    logic [63:0] e_addr, bm, ent, idx;
    int          e_reads, stride, l, ps;
    e_reads = 0; e_addr = '0;
    stride  = (int'(cfg_ew) + 1) * 3;
    e_warn  = 1'b0;
    if (!lf) begin
      if (lv == 0 || lv > 4) begin
        e_dir = b;
      end else if (b[6]) begin
        e_dir = b;
        if (b[14:13] == 2'b00) e_dir[14:13] = lv[1:0];
        e_warn = (lv == 4);
      end else begin
        idx    = (badv >> pos_t[lv]) & ((64'd1 << wid_t[lv]) - 1);
        e_addr = (b & PAM) | (idx << stride);
        e_dir  = mem_word(e_addr) & PAM;
        e_reads = 1;
      end
    end else begin
      bm = b & PAM;
      if (bm[6]) begin
        l   = int'(bm[14:13]);
        ent = bm;
        ent[14:13] = 2'b00;
        ent[6] = 1'b0;
        if (ent[12]) begin ent[12] = 1'b0; ent[6] = 1'b1; end
        ps = pos_t[l] + wid_t[l] - 1;
        if (od) ent = ent + (64'd1 << ps);
      end else begin
        idx    = (badv >> pos_t[0]) & ((64'd1 << wid_t[0]) - 1);
        idx[0] = 1'b0;
        e_addr = bm | ((idx + 64'(od)) << stride);
        ent    = mem_word(e_addr) & PAM;
        ps     = pos_t[0];
        e_reads = 1;
      end
      if (od) e_lo1 = ent; else e_lo0 = ent;
      e_ps = 6'(ps);
    end

    mon_en = 1'b0;
    latency = lat;
    begin
      int r0;
      r0 = nreads;
      @(negedge clk);
      op_leaf = lf; level = lv; odd = od; base = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (busy_poke) begin
        // Attempt a different step while the read is pending (R9)
        op_leaf = 1'b0; level = 3'd0; base = 64'hDEAD; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk({rq, " read count"}, 64'(nreads - r0), 64'(e_reads));
      if (e_reads == 1) chk({rq, " read address"}, last_addr, e_addr);
      chk({rq, " dir_out"}, dir_out, e_dir);
      chk({rq, " lo0"}, lo0, e_lo0);
      chk({rq, " lo1"}, lo1, e_lo1);
      chk({rq, " ps_out"}, 64'(ps_out), 64'(e_ps));
      chk({rq, " warn"}, 64'(huge_l4_warn), 64'(e_warn));
      mon_en = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    badv = 64'h0000_1A2B_3C4D_5E6F;
    repeat (3) @(negedge clk);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 rd_req", 64'(rd_req), 64'd0);
    chk("R1 dir_out", dir_out, 64'd0);
    chk("R1 lo0", lo0, 64'd0);
    chk("R1 ps_out", 64'(ps_out), 64'd0);
    rst = 1'b0;

    // R2 / R3 directory reads at several strides and latencies
    cfg_ew = 2'd0; run_step(1'b0, 3'd1, 1'b0, 64'h0000_0000_0040_0000 & ~64'h40, 1, 1'b0, "R2 R3 L1 ew0");
    cfg_ew = 2'd1; run_step(1'b0, 3'd2, 1'b0, 64'h0000_0001_2340_0000, 3, 1'b0, "R2 R3 L2 ew1");
    cfg_ew = 2'd3; run_step(1'b0, 3'd3, 1'b0, 64'hFFFF_0002_0000_0000, 2, 1'b0, "R2 R3 L3 ew3 masked");
    cfg_ew = 2'd2; run_step(1'b0, 3'd4, 1'b0, 64'h0000_0000_8000_0000, 1, 1'b0, "R2 L4 ew2");

    // R4 illegal levels
    run_step(1'b0, 3'd0, 1'b0, 64'hABCD_0000_1234_5600, 1, 1'b0, "R4 level0");
    run_step(1'b0, 3'd5, 1'b0, 64'h1111_2222_3333_4400, 1, 1'b0, "R4 level5");
    run_step(1'b0, 3'd7, 1'b0, 64'h0000_0000_0000_0000, 1, 1'b0, "R4 level7");

    // R5 huge passthrough
    run_step(1'b0, 3'd2, 1'b0, 64'h0000_0040_0000_1040, 1, 1'b0, "R5 huge set level");
    run_step(1'b0, 3'd3, 1'b0, 64'h0000_0040_0000_2040, 1, 1'b0, "R5 huge keep level");
    // R11 level-4 huge warning
    run_step(1'b0, 3'd4, 1'b0, 64'h0000_0080_0000_0040, 1, 1'b0, "R11 huge l4");

    // R6 / R8 normal leaf, even and odd; badv leaf index odd
    cfg_ew = 2'd0;
    badv = 64'h0000_0000_0012_3000;
    run_step(1'b1, 3'd0, 1'b0, 64'h0000_0000_0070_0000, 2, 1'b0, "R6 R8 leaf even");
    run_step(1'b1, 3'd0, 1'b1, 64'h0000_0000_0070_0000, 1, 1'b0, "R6 R8 leaf odd");
    cfg_ew = 2'd1;
    run_step(1'b1, 3'd0, 1'b1, 64'hF000_0000_0090_0000, 2, 1'b0, "R6 leaf odd ew1 masked");

    // R8 directory step leaves refill fields alone
    run_step(1'b0, 3'd1, 1'b0, 64'h0000_0000_0050_0000, 1, 1'b0, "R8 dir keeps lo");

    // R7 huge leaf split, with and without the huge-global bit
    run_step(1'b1, 3'd0, 1'b0, 64'h0000_0080_0000_5043, 1, 1'b0, "R7 huge even hglobal");
    run_step(1'b1, 3'd0, 1'b1, 64'h0000_0080_0000_5043, 1, 1'b0, "R7 huge odd hglobal");
    run_step(1'b1, 3'd0, 1'b1, 64'h0000_0000_4000_2047, 1, 1'b0, "R7 huge odd l1");

    // R9 start while a read is pending is ignored
    cfg_ew = 2'd0;
    run_step(1'b0, 3'd2, 1'b0, 64'h0000_0000_0300_0000, 5, 1'b1, "R9 busy start");
    run_step(1'b1, 3'd0, 1'b0, 64'h0000_0000_0310_0000, 4, 1'b1, "R9 busy start leaf");

    // R10 hold across idle cycles
    repeat (6) @(negedge clk);
    chk("R10 done still high", 64'(done), 64'd1);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule